// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A synthesizable behavioural model of a synchronous pipelined SRAM whose reads and writes share one two-cycle data latency. Because both directions use the same pipeline, read and write commands can alternate on consecutive clock edges and the data bus never needs an idle cycle between them.

Each rising edge with the clock enable high captures the address and the control inputs. A load starts a new access at the external address. Later advance cycles step a 2-bit beat counter, so one address gives four beats. The beats follow linear or interleaved order.

The shared data bus is split into three ports:
- `din`, which the model samples;
- `dout`, which the model drives;
- `dq_oe`, which says when `dout` would be driven.

This split lets a testbench compare read data against a reference array. An asynchronous output enable and a sleep input both force the bus to high impedance.

Top module: `zt_sram`

## Requirements
- R1: A read captured at rising edge n drives `dout` and raises `dq_oe` right after edge n+1. Both hold until edge n+2. The data is the word stored at the read address.
- R2: A write captured at edge n takes `din` at edge n+2 and stores it at the captured address.
- R3: With `adv`=1 and a burst active, each enabled edge issues the next beat with the same direction as the load. With `lin_order`=1, the low two address bits of beat k are (loaded low bits + k) mod 4 and the upper bits are unchanged. After beat 3 the order wraps to beat 0.
- R4: With `lin_order`=0 (interleaved), the low two address bits of beat k are the loaded low bits XOR k.
- R5: A load (`adv`=0) while any of `en_a`, `en_b`, `en_c` is low starts no access and ends any burst, so later advances issue nothing. Accesses already in the pipeline still complete. The bus is high impedance two cycles after the deselect.
- R6: A write command gives `dq_oe`=0 in its data cycle. Reads and writes may alternate on every edge and each keeps its own two-cycle timing.
- R7: `byte_en` bit b selects lane b, which is bits [b*LANE_W +: LANE_W] of `din` and of the stored word. A lane holds one byte with its parity bit. Unselected lanes keep their old value, and a write with `byte_en`=0 changes nothing. Byte enables are captured with the command.
- R8: While `clk_en`=0, all synchronous inputs are ignored. Every register holds its value, including the pipeline, the burst state, `dout` and `dq_oe`, and no write is committed.
- R9: `out_en`=0 forces `dq_oe` low at once, with no clock edge needed. Raising `out_en` again restores it.
- R10: While `sleep`=1, no access starts, any burst ends and the pipeline is emptied. `dq_oe` is 0 during sleep and stays 0 after sleep ends until a new read reaches its data cycle.
- R11: A read issued on the edge right after a write to the same address returns the newly written lanes merged with the old unselected lanes.
- R12: After reset (`rst_n`=0 for at least one edge), `dq_oe` is 0 and no access is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of pipeline and burst state |
| clk_en | input | 1 | 1 = edge is acted on, 0 = everything holds |
| en_a | input | 1 | Chip enable, active high |
| en_b | input | 1 | Chip enable, active high |
| en_c | input | 1 | Chip enable, active high |
| adv | input | 1 | 0 = load external address, 1 = advance burst |
| wr | input | 1 | On a load: 1 = write, 0 = read |
| byte_en | input | LANES | Per-lane write select, active high |
| lin_order | input | 1 | 1 = linear beat order, 0 = interleaved |
| out_en | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Sleep request, active high |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data half of the bus |
| dout | output | LANES*LANE_W | Read data half of the bus |
| dq_oe | output | 1 | 1 when `dout` is driven on the bus |

## Verification
The riskiest case is a read that directly follows a write to the same word. If the forwarding from the committing write is missing, the read returns the stale word, or the old word without the new lanes. The bench also runs four-beat bursts in both orders starting from every low-bit offset. A counter that adds where it should XOR, or that lets a carry reach the upper address bits, would read or write the wrong word. Deselects in the middle of a burst, clock-enable stalls with garbage on the inputs, and sleep entry are all checked. A design that kept issuing beats after these events, let the pipeline slip during a stall, or re-drove the bus on waking would show `dq_oe` or data in the wrong cycle. Zero and partial byte enables are also exercised, so a model that applied the enables of the wrong command would be seen to corrupt lanes.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

   // low two address bits of beat n, given the loaded low bits
   function automatic logic [1:0] beat_low(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic       lin);
      return lin ? (base + n) : (base ^ n);
   endfunction

endpackage

// File: rtl/zt_burst_ctl.sv
`timescale 1ns/1ps
module zt_burst_ctl
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              sleep,
   input  logic              load,
   input  logic              sel_ok,
   input  logic              wr,
   input  logic              lin,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  be,
   output logic              iss_vld,
   output logic              iss_wr,
   output logic [ADDR_W-1:0] iss_addr,
   output logic [LANES-1:0]  iss_be
);

   logic              act;
   logic              dir_w;
   logic [ADDR_W-1:0] base;
   logic [1:0]        cnt;
   logic [1:0]        cnt_nx;

   assign cnt_nx = cnt + 2'd1;

   always_comb begin
      iss_be = be;
      if (load) begin
         iss_vld  = sel_ok && !sleep;
         iss_wr   = wr;
         iss_addr = addr;
      end else begin
         iss_vld  = act && !sleep;
         iss_wr   = dir_w;
         iss_addr = {base[ADDR_W-1:2], beat_low(base[1:0], cnt_nx, lin)};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act   <= 1'b0;
         dir_w <= 1'b0;
         base  <= '0;
         cnt   <= 2'd0;
      end else if (sleep) begin
         act <= 1'b0;
      end else if (step) begin
         if (load) begin
            act   <= sel_ok;
            dir_w <= wr;
            base  <= addr;
            cnt   <= 2'd0;
         end else if (act) begin
            cnt <= cnt_nx;
         end
      end
   end

   // R3: an accepted advance moves the beat counter on by exactly one
   p_adv_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !sleep && !load && act) |=> (cnt == $past(cnt) + 2'd1));

   // R5: a deselected load leaves no burst running
   p_desel_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !sleep && load && !sel_ok) |=> !act);

endmodule

// File: rtl/zt_pipe.sv
`timescale 1ns/1ps
module zt_pipe #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              sleep,
   input  logic              iss_vld,
   input  logic              iss_wr,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic [LANES-1:0]  iss_be,
   output logic              rd_go,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_go,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LANES-1:0]  wr_be,
   output logic              oe_q
);

   localparam int NSTG = 2;

   logic              st_vld  [NSTG];
   logic              st_wr   [NSTG];
   logic [ADDR_W-1:0] st_addr [NSTG];
   logic [LANES-1:0]  st_be   [NSTG];

   always_ff @(posedge clk) begin
      if (!rst_n || sleep) begin
         for (int i = 0; i < NSTG; i++) begin
            st_vld[i] <= 1'b0;
            st_wr[i]  <= 1'b0;
         end
         oe_q <= 1'b0;
      end else if (step) begin
         st_vld[0]  <= iss_vld;
         st_wr[0]   <= iss_wr;
         st_addr[0] <= iss_addr;
         st_be[0]   <= iss_be;
         for (int i = 1; i < NSTG; i++) begin
            st_vld[i]  <= st_vld[i-1];
            st_wr[i]   <= st_wr[i-1];
            st_addr[i] <= st_addr[i-1];
            st_be[i]   <= st_be[i-1];
         end
         oe_q <= st_vld[0] && !st_wr[0];
      end
   end

   assign rd_go   = rst_n && step && !sleep && st_vld[0] && !st_wr[0];
   assign rd_addr = st_addr[0];
   assign wr_go   = rst_n && step && !sleep && st_vld[NSTG-1] && st_wr[NSTG-1];
   assign wr_addr = st_addr[NSTG-1];
   assign wr_be   = st_be[NSTG-1];

   // R8: with the clock disabled the pipeline and the bus driver hold
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !sleep) |=> ($stable(st_vld[0]) && $stable(st_vld[NSTG-1]) && $stable(oe_q)));

   // R6: a write leaving the first stage never turns the bus on
   p_wr_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !sleep && st_vld[0] && st_wr[0]) |=> !oe_q);

   // R10: sleep empties the pipeline
   p_sleep_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!oe_q && !st_vld[0] && !st_vld[NSTG-1]));

endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
module zt_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_be,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DW    = LANES * LANE_W;
   localparam int DEPTH = 1 << ADDR_W;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] old_word;
   logic [DW-1:0] wr_word;
   logic [DW-1:0] rd_word;

   assign old_word = mem[wr_addr];

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign wr_word[b*LANE_W +: LANE_W] = wr_be[b] ? din[b*LANE_W +: LANE_W]
                                                    : old_word[b*LANE_W +: LANE_W];
   end

   // forward the word committing on this same edge
   assign rd_word = (wr_en && (wr_addr == rd_addr)) ? wr_word : mem[rd_addr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_word;
      if (rd_en) rdata <= rd_word;
   end

   // R7: a commit with every lane deselected leaves the word untouched
   p_nobyte_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_be == '0)) |=> (mem[$past(wr_addr)] == $past(old_word)));

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en,
   input  logic                    en_a,
   input  logic                    en_b,
   input  logic                    en_c,
   input  logic                    adv,
   input  logic                    wr,
   input  logic [LANES-1:0]        byte_en,
   input  logic                    lin_order,
   input  logic                    out_en,
   input  logic                    sleep,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dq_oe
);

   localparam int DW = LANES * LANE_W;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("zt_sram: ADDR_W must be at least 3");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("zt_sram: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("zt_sram: LANE_W must be at least 1");
   end

   logic              iss_vld;
   logic              iss_wr;
   logic [ADDR_W-1:0] iss_addr;
   logic [LANES-1:0]  iss_be;
   logic              rd_go;
   logic [ADDR_W-1:0] rd_addr;
   logic              wr_go;
   logic [ADDR_W-1:0] wr_addr;
   logic [LANES-1:0]  wr_be;
   logic              oe_q;
   logic [DW-1:0]     rdata;

   zt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (clk_en),
      .sleep    (sleep),
      .load     (!adv),
      .sel_ok   (en_a && en_b && en_c),
      .wr       (wr),
      .lin      (lin_order),
      .addr     (addr),
      .be       (byte_en),
      .iss_vld  (iss_vld),
      .iss_wr   (iss_wr),
      .iss_addr (iss_addr),
      .iss_be   (iss_be)
   );

   zt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (clk_en),
      .sleep    (sleep),
      .iss_vld  (iss_vld),
      .iss_wr   (iss_wr),
      .iss_addr (iss_addr),
      .iss_be   (iss_be),
      .rd_go    (rd_go),
      .rd_addr  (rd_addr),
      .wr_go    (wr_go),
      .wr_addr  (wr_addr),
      .wr_be    (wr_be),
      .oe_q     (oe_q)
   );

   zt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_go),
      .rd_addr (rd_addr),
      .wr_en   (wr_go),
      .wr_addr (wr_addr),
      .wr_be   (wr_be),
      .din     (din),
      .rdata   (rdata)
   );

   assign dout  = rdata;
   assign dq_oe = oe_q && out_en && !sleep;

endmodule

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

   localparam int CLK_PER = 10;
   localparam int AW      = 6;
   localparam int NL      = 4;
   localparam int LW      = 9;
   localparam int DW      = NL * LW;
   localparam int DEPTH   = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b1;
   logic          en_a = 1'b0, en_b = 1'b0, en_c = 1'b0;
   logic          adv = 1'b0;
   logic          wr = 1'b0;
   logic [NL-1:0] byte_en = '0;
   logic          lin_order = 1'b0;
   logic          out_en = 1'b1;
   logic          sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dq_oe;

   zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_zt_sram (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .en_a(en_a), .en_b(en_b), .en_c(en_c),
      .adv(adv), .wr(wr), .byte_en(byte_en), .lin_order(lin_order), .out_en(out_en),
      .sleep(sleep), .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
   );

   always #(CLK_PER/2) clk = ~clk;

   int    total = 0;
   int    bad = 0;
   int    cyc = 0;
   bit    done = 1'b0;
   string cur_req = "R12";

   task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   typedef struct {
      bit            v;
      bit            w;
      logic [AW-1:0] a;
      logic [NL-1:0] be;
   } op_t;

   op_t           q[$];
   op_t           bub;
   logic [DW-1:0] mem_m [DEPTH];
   bit            act_m = 1'b0;
   bit            dirw_m = 1'b0;
   logic [AW-1:0] base_m = '0;
   int            beat_m = 0;
   bit            exp_oe = 1'b0;
   logic [DW-1:0] exp_d = '0;

   initial begin
      bub = '{v: 1'b0, w: 1'b0, a: '0, be: '0};
      q = '{bub, bub};
   end

   always @(posedge clk) begin
      if (!rst_n || sleep) begin
         q = '{bub, bub};
         act_m = 1'b0;
         exp_oe = 1'b0;
      end else if (clk_en) begin
         op_t old;
         op_t nw;
         old = q.pop_front();
         if (old.v && old.w)
            for (int b = 0; b < NL; b++)
               if (old.be[b]) mem_m[old.a][b*LW +: LW] = din[b*LW +: LW];
         nw = bub;
         if (!adv) begin
            if (en_a && en_b && en_c) begin
               act_m = 1'b1; dirw_m = wr; base_m = addr; beat_m = 0;
               nw = '{v: 1'b1, w: wr, a: addr, be: byte_en};
            end else begin
               act_m = 1'b0;
            end
         end else if (act_m) begin
            int lo;
            beat_m = (beat_m + 1) % 4;
            lo = lin_order ? ((int'(base_m[1:0]) + beat_m) % 4) : (int'(base_m[1:0]) ^ beat_m);
            nw = '{v: 1'b1, w: dirw_m, a: {base_m[AW-1:2], 2'(lo)}, be: byte_en};
         end
         q.push_back(nw);
         exp_oe = q[0].v && !q[0].w;
         exp_d  = mem_m[q[0].a];
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e;
         e = exp_oe && out_en && !sleep;
         chk(cur_req, dq_oe == e, 64'(dq_oe), 64'(e));
         if (e) chk(cur_req, dout === exp_d, 64'(dout), 64'(exp_d));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 20000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(input bit ld, input bit w, input int a, input logic [NL-1:0] be, input logic [2:0] s);
      @(negedge clk); #1;
      adv = !ld; wr = w; addr = AW'(a); byte_en = be;
      {en_a, en_b, en_c} = s;
      din = {$urandom, $urandom};
   endtask
   task automatic rd(input int a);                     drive(1, 0, a, '0, 3'b111); endtask
   task automatic wrt(input int a, input logic [NL-1:0] be); drive(1, 1, a, be, 3'b111); endtask
   task automatic advn(input logic [NL-1:0] be);        drive(0, 0, 0, be, 3'b000); endtask
   task automatic idle();                               drive(1, 0, 0, '0, 3'b000); endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1 rst_n = 1'b1;
      @(negedge clk); #2;
      chk("R12", dq_oe == 1'b0, 64'(dq_oe), 64'd0);

      cur_req = "R2";                              // fill the whole array
      for (int i = 0; i < DEPTH; i++) wrt(i, '1);
      repeat (3) idle();

      cur_req = "R1";
      for (int i = 0; i < 16; i++) rd((i * 7 + 3) % DEPTH);
      repeat (3) idle();

      cur_req = "R6";                              // alternate on every edge
      for (int i = 0; i < 12; i++) begin
         wrt(i + 10, '1);
         rd(i + 30);
      end
      repeat (3) idle();

      cur_req = "R11";                             // write then read same word
      for (int i = 0; i < 8; i++) begin
         wrt(40 + i, NL'(i * 5 + 1));
         rd(40 + i);
      end
      repeat (3) idle();

      cur_req = "R7";
      wrt(20, '0); wrt(21, 4'b0101); wrt(22, 4'b1000); rd(20); rd(21); rd(22);
      wrt(20, '0); rd(20);
      repeat (3) idle();

      cur_req = "R3";
      lin_order = 1'b1;
      for (int s = 0; s < 4; s++) begin
         rd(8 + s); repeat (5) advn('0);
         wrt(16 + s, '1); repeat (3) advn(4'b0110);
         rd(16 + s); repeat (3) advn('0);
      end
      repeat (3) idle();

      cur_req = "R4";
      lin_order = 1'b0;
      for (int s = 0; s < 4; s++) begin
         wrt(24 + s, '1); repeat (3) advn('1);
         rd(24 + s); repeat (5) advn('0);
      end
      repeat (3) idle();

      cur_req = "R5";
      rd(50); advn('0);
      drive(1, 0, 51, '0, 3'b011); advn('0); advn('0);
      wrt(52, '1); advn('1);
      drive(1, 1, 53, '1, 3'b101); advn('1);
      rd(52); drive(1, 0, 54, '0, 3'b110); advn('0); advn('0);
      repeat (3) idle();

      cur_req = "R8";
      rd(12); advn('0);
      @(negedge clk); #1 clk_en = 1'b0;
      for (int i = 0; i < 4; i++) drive(i % 2, i % 2, 60 + i, '1, 3'b111);
      @(negedge clk); #1 clk_en = 1'b1; adv = 1'b1;
      advn('0); wrt(13, '1); advn('1);
      @(negedge clk); #1 clk_en = 1'b0;
      repeat (3) drive(1, 1, 2, '1, 3'b111);
      @(negedge clk); #1 clk_en = 1'b1; adv = 1'b1;
      advn('1); rd(13); rd(14);
      repeat (3) idle();

      cur_req = "R9";
      rd(5); rd(6); rd(7);
      #2 out_en = 1'b0;
      #1 chk("R9", dq_oe == 1'b0, 64'(dq_oe), 64'd0);
      #1 out_en = 1'b1;
      #1 chk("R9", dq_oe == exp_oe, 64'(dq_oe), 64'(exp_oe));
      rd(8); idle();
      #1 out_en = 1'b0;
      idle();
      #1 out_en = 1'b1;
      repeat (3) idle();

      cur_req = "R10";
      rd(30); rd(31); idle();
      @(negedge clk); #1 sleep = 1'b1;
      for (int i = 0; i < 3; i++) drive(1, 0, 33 + i, '0, 3'b111);
      @(negedge clk); #1 sleep = 1'b0; adv = 1'b1;
      @(negedge clk); #2;
      chk("R10", dq_oe == 1'b0, 64'(dq_oe), 64'd0);
      idle(); idle();
      rd(36); advn('0);
      repeat (4) idle();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule